// File: doc/BRIEF.md
# Register Rename Map with Free List

This block performs explicit register renaming for an out-of-order core. The core has more physical registers than architectural ones. A mapping table holds, for each architectural register, the physical register that currently carries its newest value. For each decoded instruction, the block looks up the physical registers of its two source operands. If the instruction writes a result, the block takes a fresh physical register from a free list and points the destination's mapping at it. The block also reports the mapping that the destination had before. That previous register stays live until the instruction commits. The commit path then hands it back to the free list.

The free list is a circular FIFO of physical indices. Allocation pops from its head and commit pushes to its tail. Decode uses a valid/ready handshake. It stalls only when the instruction needs a destination and the free list has nothing left. The renamed result appears on registered outputs one cycle after the instruction is accepted. The block handles one rename and one commit per cycle. It defaults to 16 architectural and 32 physical registers.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i, so a source lookup of register i returns i.
- R2: After reset, the free list holds physical registers ARCH_REGS up to PHYS_REGS-1. Successive allocations hand these out in ascending order.
- R3: Source lookups see the mapping as it stood before the same instruction's destination update. An instruction whose source equals its destination gets the older physical register for that source.
- R4: After an accepted instruction with a destination, later lookups of that architectural register return the newly allocated physical register. `ren_old_phys` reports the physical register that was mapped to the destination just before.
- R5: An instruction with `dec_has_dst`=0 allocates nothing. It changes no mapping and reports `ren_has_dst`=0 with `ren_new_phys`=0 and `ren_old_phys`=0.
- R6: `dec_ready` is 0 exactly when `dec_has_dst`=1 and the free list is empty at the start of the cycle. A commit in that same cycle does not lift the stall. Instructions without a destination are always accepted.
- R7: A committed physical register is appended at the tail of the free list. It is handed out only after every entry that was already free.
- R8: `ren_valid` is 1 in the cycle after an accepted instruction (`dec_valid` and `dec_ready` both 1 at the clock edge) and 0 otherwise. The renamed fields are registered alongside it.
- R9: An instruction offered while `dec_ready` is 0 changes neither the mapping table nor the free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_ready | output | 1 | Block can accept the offered instruction |
| dec_src_a | input | 4 | First source architectural register |
| dec_src_b | input | 4 | Second source architectural register |
| dec_has_dst | input | 1 | Instruction writes a destination |
| dec_dst | input | 4 | Destination architectural register |
| ren_valid | output | 1 | Renamed instruction present (one cycle after acceptance) |
| ren_phys_a | output | 5 | Physical register for first source |
| ren_phys_b | output | 5 | Physical register for second source |
| ren_has_dst | output | 1 | Renamed instruction has a destination |
| ren_new_phys | output | 5 | Newly allocated destination physical register |
| ren_old_phys | output | 5 | Previous physical mapping of the destination, freed at commit |
| commit_valid | input | 1 | A committing instruction frees a register |
| commit_free_phys | input | 5 | Physical register returned to the free list |

## Verification
The first directed sweep renames one no-destination instruction per architectural register. Against identity mapping, this separates a correct reset table from a shifted or stale one. A run of sixteen allocations, each reading its own destination, then drains the free list. It exposes the allocation order and any read-after-update error in source lookups. With the list empty, a destination instruction is offered and stalls. A no-destination instruction follows, which shows both the stall and that the stalled instruction left no trace. Commits then refill the list, and the next allocations show tail-append ordering. Seeded random traffic after that mixes stalls, simultaneous commits and reuse of the same registers, all against a bench model of the table and FIFO.

// File: rtl/rename_pkg.sv
package rename_pkg;

  localparam int DEF_ARCH_REGS = 16;
  localparam int DEF_PHYS_REGS = 32;

  // Advance a circular index that wraps at an arbitrary depth.
  function automatic int wrap_inc(input int idx, input int depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

  // Occupancy after one cycle of optional push and pop.
  function automatic int next_count(input int cnt, input bit push, input bit pop);
    return cnt + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // Physical index initially stored at free-list slot k.
  function automatic int initial_free(input int arch_regs, input int slot);
    return arch_regs + slot;
  endfunction

endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int ARCH_REGS = 16,
  parameter int AW        = 4,
  parameter int PW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_arch,
  input  logic [AW-1:0] rd_b_arch,
  input  logic [AW-1:0] rd_c_arch,
  output logic [PW-1:0] rd_a_phys,
  output logic [PW-1:0] rd_b_phys,
  output logic [PW-1:0] rd_c_phys,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_arch,
  input  logic [PW-1:0] wr_phys
);

  logic [PW-1:0] map_q [ARCH_REGS];

  // Reads return the state before this cycle's write.
  assign rd_a_phys = map_q[rd_a_arch];
  assign rd_b_phys = map_q[rd_b_arch];
  assign rd_c_phys = map_q[rd_c_arch];

  generate
    for (genvar g = 0; g < ARCH_REGS; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          map_q[g] <= PW'(g);
        end else if (wr_en && (wr_arch == AW'(g))) begin
          map_q[g] <= wr_phys;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/rename_free_list.sv
module rename_free_list #(
  parameter int ARCH_REGS = 16,
  parameter int DEPTH     = 16,
  parameter int PW        = 5,
  localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  output logic [PW-1:0] head_phys,
  input  logic          push,
  input  logic [PW-1:0] push_phys,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);

  logic [PW-1:0] slot_q [DEPTH];
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  assign head_phys = slot_q[head_q];
  assign empty     = (count_q == '0);
  assign full      = (count_q == CW'(DEPTH));
  assign count     = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= CW'(DEPTH);
    end else begin
      if (pop)  head_q <= IW'(rename_pkg::wrap_inc(int'(head_q), DEPTH));
      if (push) tail_q <= IW'(rename_pkg::wrap_inc(int'(tail_q), DEPTH));
      count_q <= CW'(rename_pkg::next_count(int'(count_q), push, pop));
    end
  end

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          slot_q[s] <= PW'(rename_pkg::initial_free(ARCH_REGS, s));
        end else if (push && (tail_q == IW'(s))) begin
          slot_q[s] <= push_phys;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/rename_out_stage.sv
module rename_out_stage #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] phys_a,
  input  logic [PW-1:0] phys_b,
  input  logic          has_dst,
  input  logic [PW-1:0] new_phys,
  input  logic [PW-1:0] old_phys,
  output logic          out_valid,
  output logic [PW-1:0] out_phys_a,
  output logic [PW-1:0] out_phys_b,
  output logic          out_has_dst,
  output logic [PW-1:0] out_new_phys,
  output logic [PW-1:0] out_old_phys
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_phys_a   <= '0;
      out_phys_b   <= '0;
      out_has_dst  <= 1'b0;
      out_new_phys <= '0;
      out_old_phys <= '0;
    end else begin
      out_valid <= load;
      if (load) begin
        out_phys_a   <= phys_a;
        out_phys_b   <= phys_b;
        out_has_dst  <= has_dst;
        out_new_phys <= has_dst ? new_phys : '0;
        out_old_phys <= has_dst ? old_phys : '0;
      end
    end
  end

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int ARCH_REGS = rename_pkg::DEF_ARCH_REGS,
  parameter int PHYS_REGS = rename_pkg::DEF_PHYS_REGS,
  localparam int AW       = $clog2(ARCH_REGS),
  localparam int PW       = $clog2(PHYS_REGS),
  localparam int FL_DEPTH = PHYS_REGS - ARCH_REGS,
  localparam int CW       = $clog2(FL_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  output logic          dec_ready,
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  input  logic          dec_has_dst,
  input  logic [AW-1:0] dec_dst,
  output logic          ren_valid,
  output logic [PW-1:0] ren_phys_a,
  output logic [PW-1:0] ren_phys_b,
  output logic          ren_has_dst,
  output logic [PW-1:0] ren_new_phys,
  output logic [PW-1:0] ren_old_phys,
  input  logic          commit_valid,
  input  logic [PW-1:0] commit_free_phys
);

  // Named internal events, observed by the bound checker.
  logic          dec_fire;
  logic          alloc_fire;
  logic          commit_fire;
  logic          fl_empty;
  logic          fl_full;
  logic [CW-1:0] fl_count;
  logic [PW-1:0] fl_head_phys;
  logic [PW-1:0] lk_phys_a;
  logic [PW-1:0] lk_phys_b;
  logic [PW-1:0] lk_old_dst;

  assign dec_ready   = !(dec_has_dst && fl_empty);
  assign dec_fire    = dec_valid && dec_ready;
  assign alloc_fire  = dec_fire && dec_has_dst;
  assign commit_fire = commit_valid;

  rename_map_table #(
    .ARCH_REGS (ARCH_REGS),
    .AW        (AW),
    .PW        (PW)
  ) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_arch (dec_src_a),
    .rd_b_arch (dec_src_b),
    .rd_c_arch (dec_dst),
    .rd_a_phys (lk_phys_a),
    .rd_b_phys (lk_phys_b),
    .rd_c_phys (lk_old_dst),
    .wr_en     (alloc_fire),
    .wr_arch   (dec_dst),
    .wr_phys   (fl_head_phys)
  );

  rename_free_list #(
    .ARCH_REGS (ARCH_REGS),
    .DEPTH     (FL_DEPTH),
    .PW        (PW)
  ) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop       (alloc_fire),
    .head_phys (fl_head_phys),
    .push      (commit_fire),
    .push_phys (commit_free_phys),
    .empty     (fl_empty),
    .full      (fl_full),
    .count     (fl_count)
  );

  rename_out_stage #(
    .PW (PW)
  ) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (dec_fire),
    .phys_a       (lk_phys_a),
    .phys_b       (lk_phys_b),
    .has_dst      (dec_has_dst),
    .new_phys     (fl_head_phys),
    .old_phys     (lk_old_dst),
    .out_valid    (ren_valid),
    .out_phys_a   (ren_phys_a),
    .out_phys_b   (ren_phys_b),
    .out_has_dst  (ren_has_dst),
    .out_new_phys (ren_new_phys),
    .out_old_phys (ren_old_phys)
  );

endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int PW       = 5,
  parameter int FL_DEPTH = 16,
  parameter int CW       = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_fire,
  input logic          alloc_fire,
  input logic          commit_fire,
  input logic          fl_empty,
  input logic          fl_full,
  input logic [CW-1:0] fl_count,
  input logic          ren_valid,
  input logic          ren_has_dst,
  input logic [PW-1:0] ren_new_phys,
  input logic [PW-1:0] ren_old_phys
);

  // R8
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> ren_valid);

  // R8
  idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_fire |=> !ren_valid);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !fl_empty);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> (!fl_full || alloc_fire));

  // R5
  nodst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !ren_has_dst) |-> (ren_new_phys == '0 && ren_old_phys == '0));

  // R4
  new_differs_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_has_dst) |-> (ren_new_phys != ren_old_phys));

  // R9
  count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (int'(fl_count) ==
      int'($past(fl_count)) + int'($past(commit_fire)) - int'($past(alloc_fire))));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fl_count) <= FL_DEPTH);

endmodule

bind rename_unit rename_unit_chk #(
  .PW       (PW),
  .FL_DEPTH (FL_DEPTH),
  .CW       (CW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_fire     (dec_fire),
  .alloc_fire   (alloc_fire),
  .commit_fire  (commit_fire),
  .fl_empty     (fl_empty),
  .fl_full      (fl_full),
  .fl_count     (fl_count),
  .ren_valid    (ren_valid),
  .ren_has_dst  (ren_has_dst),
  .ren_new_phys (ren_new_phys),
  .ren_old_phys (ren_old_phys)
);

// File: tb/rename_unit_bench.sv
module rename_unit_bench;

  localparam int NA = 16;
  localparam int NP = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_valid = 1'b0;
  logic       dec_ready;
  logic [3:0] dec_src_a = '0;
  logic [3:0] dec_src_b = '0;
  logic       dec_has_dst = 1'b0;
  logic [3:0] dec_dst = '0;
  logic       ren_valid;
  logic [4:0] ren_phys_a, ren_phys_b, ren_new_phys, ren_old_phys;
  logic       ren_has_dst;
  logic       commit_valid = 1'b0;
  logic [4:0] commit_free_phys = '0;

  always #5 clk = ~clk;

  rename_unit u_rename_unit (
    .clk (clk), .rst_n (rst_n),
    .dec_valid (dec_valid), .dec_ready (dec_ready),
    .dec_src_a (dec_src_a), .dec_src_b (dec_src_b),
    .dec_has_dst (dec_has_dst), .dec_dst (dec_dst),
    .ren_valid (ren_valid), .ren_phys_a (ren_phys_a), .ren_phys_b (ren_phys_b),
    .ren_has_dst (ren_has_dst), .ren_new_phys (ren_new_phys),
    .ren_old_phys (ren_old_phys),
    .commit_valid (commit_valid), .commit_free_phys (commit_free_phys)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int model_map [NA];
  int free_q [$];
  int live_q [$];

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle: called just after a falling edge.
  task automatic step(input bit v, input int sa, input int sb, input bit hd,
                      input int d, input bit cv, input int cp, input string req);
    bit exp_rdy, acc;
    int e_a, e_b, e_new, e_old;
    dec_valid = v; dec_src_a = 4'(sa); dec_src_b = 4'(sb);
    dec_has_dst = hd; dec_dst = 4'(d);
    commit_valid = cv; commit_free_phys = 5'(cp);
    #1;
    exp_rdy = !(hd && free_q.size() == 0);
    chk(int'(dec_ready), int'(exp_rdy), "R6", "dec_ready");
    acc = v && exp_rdy;
    e_a = model_map[sa]; e_b = model_map[sb]; e_new = 0; e_old = 0;
    if (acc && hd) begin
      e_new = free_q.pop_front();
      e_old = model_map[d];
      model_map[d] = e_new;
      live_q.push_back(e_old);
    end
    if (cv) free_q.push_back(cp);
    @(posedge clk);
    @(negedge clk);
    chk(int'(ren_valid), int'(acc), "R8", "ren_valid");
    if (acc) begin
      chk(int'(ren_phys_a), e_a, req, "ren_phys_a");
      chk(int'(ren_phys_b), e_b, req, "ren_phys_b");
      chk(int'(ren_has_dst), int'(hd), req, "ren_has_dst");
      chk(int'(ren_new_phys), e_new, hd ? req : "R5", "ren_new_phys");
      chk(int'(ren_old_phys), e_old, hd ? req : "R5", "ren_old_phys");
    end
    dec_valid = 1'b0; commit_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    for (int i = 0; i < NA; i++) model_map[i] = i;
    for (int k = NA; k < NP; k++) free_q.push_back(k);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(int'(ren_valid), 0, "R8", "ren_valid after reset");
    chk(int'(dec_ready), 1, "R6", "dec_ready after reset");

    // R1: identity mapping, no destination
    for (int i = 0; i < NA; i++) step(1, i, (i + 1) % NA, 0, 0, 0, 0, "R1");
    // R2 and R3: drain the free list, each instruction reads its own destination
    for (int k = 0; k < NA; k++) step(1, k, 15 - k, 1, k, 0, 0, "R2");
    // R6: empty list stalls a destination write, R9: it leaves no trace
    step(1, 0, 0, 1, 5, 0, 0, "R6");
    step(1, 5, 5, 0, 0, 0, 0, "R9");
    // R6: commit in the stalled cycle does not lift the stall
    step(1, 1, 1, 1, 6, 1, live_q.pop_front(), "R6");
    // R7: refill out of order, then allocate from the tail-appended entries
    step(0, 0, 0, 0, 0, 1, live_q.pop_back(), "R7");
    step(0, 0, 0, 0, 0, 1, live_q.pop_front(), "R7");
    for (int k = 0; k < 3; k++) step(1, 2, 3, 1, 9 + k, 0, 0, "R7");
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 1, live_q.pop_front(), "R7");
    // R3: source equals destination
    step(1, 7, 3, 1, 7, 0, 0, "R3");
    // R4: later lookup sees the new mapping
    step(1, 7, 7, 0, 0, 0, 0, "R4");

    // R4: constrained random mix
    for (int c = 0; c < 3000; c++) begin
      bit v, hd, cv;
      int cp;
      v  = ($urandom % 10) < 8;
      hd = ($urandom % 10) < 7;
      cv = (live_q.size() > 0) && (($urandom % 10) < 4);
      cp = 0;
      if (cv) begin
        if ($urandom % 4 == 0) cp = live_q.pop_back();
        else cp = live_q.pop_front();
      end
      step(v, $urandom % NA, $urandom % NA, hd, $urandom % NA, cv, cp, "R4");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule